// File: doc/BRIEF.md
# Hardware Semaphore Bank

This block holds a small set of hardware locks. Processors use them to get exclusive access to shared flags. Each lock group has three word addresses on a plain register port:

- **Claim register.** A requester claims the lock by writing a word that carries its 3-bit identity in the top bits and a request flag just below them.
- **Status register.** The requester reads the status word back. It owns the lock when the identity field there equals its own. If not, it writes the claim again.
- **Release register.** The owner gives the lock up by writing the same identity-plus-flag word to the release register.

Identities are plain numbers picked by software. One usual scheme is cluster×4 + core for a shared group, and 6 − core for groups private to a cluster. The hardware does not know which master wrote: the identity travels in the write data.

Each group is a two-state machine with states FREE and HELD. Transition GRANT (FREE → HELD) fires on a flagged claim write and latches the writer's identity as owner. Transition RELEASE (HELD → FREE) fires on a flagged release write whose identity matches the owner. All other writes leave the state alone, including a claim against a HELD group.

Reads and writes use separate strobes and addresses, so both can occur in the same cycle. Read data is registered.

Top module: `lockbank_top`

## Requirements
- R1: After reset every group is FREE, and every status register reads 0x00000000.
- R2: A write to a FREE group's claim register with bit 28 set moves the group to HELD. Its status then reads the writer's ID in bits [31:29], bit 28 = 1 and bits [27:0] = 0.
- R3: A claim write to a HELD group, whatever its ID, leaves the owner field and bit 28 unchanged.
- R4: A release write with bit 28 set and bits [31:29] equal to the owner returns the group to FREE, so its status reads 0.
- R5: A release write whose ID differs from the owner leaves the group HELD with the same owner.
- R6: A claim or release write with bit 28 clear changes nothing.
- R7: Group g (0..2) has its claim register at byte address 12·g, release at 12·g+4 and status at 12·g+8. The groups change state independently.
- R8: A read strobed in cycle n returns on rd_data after that clock edge. It shows the state before any write in that same cycle.
- R9: Reads of unmapped addresses return 0. Writes to status or unmapped addresses change no group.
- R10: ID 0 can own a lock. Its status reads 0x10000000, which is told apart from FREE by bit 28.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 8 | Byte address of the write |
| wr_data | input | 32 | Write word: ID in [31:29], request flag in [28] |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 8 | Byte address of the read |
| rd_data | output | 32 | Registered read word |

## Verification
A status read and a release (or claim) write to the same group can land in one cycle. The bench provokes this by raising both strobes in one cycle against a HELD group, with a matching release. The read returned from that edge must still show the old owner with bit 28 set. A status read one cycle later must show the group FREE, which proves the write took effect without leaking into the read of its own cycle.

// File: rtl/lockbank_pkg.sv
package lockbank_pkg;

    typedef enum logic {
        SLOT_FREE = 1'b0,
        SLOT_HELD = 1'b1
    } slot_state_e;

    localparam int OFF_CLAIM   = 0;
    localparam int OFF_RELEASE = 4;
    localparam int OFF_STATUS  = 8;

endpackage

// File: rtl/lockbank_decode.sv
module lockbank_decode #(
    parameter int ADDR_W       = 8,
    parameter int NUM_GROUPS   = 3,
    parameter int GROUP_STRIDE = 12
) (
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [ADDR_W-1:0]     rd_addr,
    output logic [NUM_GROUPS-1:0] claim_sel,
    output logic [NUM_GROUPS-1:0] release_sel,
    output logic [NUM_GROUPS-1:0] status_sel
);
    import lockbank_pkg::*;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        localparam logic [ADDR_W-1:0] A_CLAIM   = ADDR_W'(g * GROUP_STRIDE + OFF_CLAIM);
        localparam logic [ADDR_W-1:0] A_RELEASE = ADDR_W'(g * GROUP_STRIDE + OFF_RELEASE);
        localparam logic [ADDR_W-1:0] A_STATUS  = ADDR_W'(g * GROUP_STRIDE + OFF_STATUS);

        assign claim_sel[g]   = (wr_addr == A_CLAIM);
        assign release_sel[g] = (wr_addr == A_RELEASE);
        assign status_sel[g]  = (rd_addr == A_STATUS);
    end

endmodule

// File: rtl/lockbank_slot.sv
module lockbank_slot #(
    parameter int ID_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            claim_wr,
    input  logic            release_wr,
    input  logic [ID_W-1:0] req_id,
    input  logic            req_flag,
    output logic            held,
    output logic [ID_W-1:0] owner
);
    import lockbank_pkg::*;

    slot_state_e     state_q, state_d;
    logic [ID_W-1:0] owner_q, owner_d;

    // next-state and owner update
    always_comb begin
        state_d = state_q;
        owner_d = owner_q;
        unique case (state_q)
            SLOT_FREE: begin
                if (claim_wr && req_flag) begin      // GRANT
                    state_d = SLOT_HELD;
                    owner_d = req_id;
                end
            end
            SLOT_HELD: begin
                if (release_wr && req_flag && (req_id == owner_q)) begin  // RELEASE
                    state_d = SLOT_FREE;
                    owner_d = '0;
                end
            end
            default: begin
                state_d = SLOT_FREE;
                owner_d = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SLOT_FREE;
            owner_q <= '0;
        end else begin
            state_q <= state_d;
            owner_q <= owner_d;
        end
    end

    // outputs
    always_comb begin
        held  = (state_q == SLOT_HELD);
        owner = owner_q;
    end

    // R2
    grant_takes_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!held && claim_wr && req_flag) |=> (held && owner == $past(req_id)));

    // R3
    held_owner_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (held && !(release_wr && req_flag && req_id == owner)) |=> (held && $stable(owner)));

    // R4
    match_release_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (held && release_wr && req_flag && req_id == owner) |=> (!held && owner == '0));

    // R6
    unflagged_noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!held && !(claim_wr && req_flag)) |=> (!held && owner == '0));

endmodule

// File: rtl/lockbank_top.sv
module lockbank_top #(
    parameter int ADDR_W       = 8,
    parameter int DATA_W       = 32,
    parameter int ID_W         = 3,
    parameter int NUM_GROUPS   = 3,
    parameter int GROUP_STRIDE = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int FLAG_POS = DATA_W - ID_W - 1;

    logic [NUM_GROUPS-1:0] claim_sel, release_sel, status_sel;
    logic [NUM_GROUPS-1:0] held;
    logic [ID_W-1:0]       owner  [NUM_GROUPS];
    logic [DATA_W-1:0]     status [NUM_GROUPS];
    logic [ID_W-1:0]       req_id;
    logic                  req_flag;
    logic [DATA_W-1:0]     rd_word;

    assign req_id   = wr_data[DATA_W-1 -: ID_W];
    assign req_flag = wr_data[FLAG_POS];

    lockbank_decode #(
        .ADDR_W      (ADDR_W),
        .NUM_GROUPS  (NUM_GROUPS),
        .GROUP_STRIDE(GROUP_STRIDE)
    ) u_decode (
        .wr_addr    (wr_addr),
        .rd_addr    (rd_addr),
        .claim_sel  (claim_sel),
        .release_sel(release_sel),
        .status_sel (status_sel)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_slot
        lockbank_slot #(.ID_W(ID_W)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .claim_wr  (wr_en && claim_sel[g]),
            .release_wr(wr_en && release_sel[g]),
            .req_id    (req_id),
            .req_flag  (req_flag),
            .held      (held[g]),
            .owner     (owner[g])
        );
        assign status[g] = {owner[g], held[g], {FLAG_POS{1'b0}}};
    end

    always_comb begin
        rd_word = '0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (status_sel[g]) rd_word = status[g];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_word;
    end

    // R7
    one_status_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(status_sel));

endmodule

// File: tb/tb_lockbank_top.sv
module tb_lockbank_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    lockbank_top dut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    typedef struct packed {
        logic       is_rd;
        logic [3:0] req;
        logic [7:0] addr;
        logic [31:0] val;
    } vec_t;

    localparam int NV = 27;
    // Word values: ID k with flag = (k<<29)|(1<<28)
    localparam vec_t TABLE [NV] = '{
        '{1'b1, 4'd1,  8'h08, 32'h0000_0000},  // R1 group 0 free
        '{1'b1, 4'd1,  8'h14, 32'h0000_0000},  // R1 group 1 free
        '{1'b0, 4'd2,  8'h00, 32'hB000_0000},  // claim g0, ID5
        '{1'b1, 4'd2,  8'h08, 32'hB000_0000},  // R2 owner 5
        '{1'b0, 4'd3,  8'h00, 32'h5000_0000},  // claim g0, ID2 while held
        '{1'b1, 4'd3,  8'h08, 32'hB000_0000},  // R3 still 5
        '{1'b0, 4'd5,  8'h04, 32'h5000_0000},  // release g0, wrong ID2
        '{1'b1, 4'd5,  8'h08, 32'hB000_0000},  // R5 still 5
        '{1'b0, 4'd9,  8'h08, 32'h5000_0000},  // write to status address
        '{1'b1, 4'd9,  8'h08, 32'hB000_0000},  // R9 still 5
        '{1'b0, 4'd6,  8'h04, 32'hA000_0000},  // release ID5 without flag
        '{1'b1, 4'd6,  8'h08, 32'hB000_0000},  // R6 still 5
        '{1'b0, 4'd4,  8'h04, 32'hB000_0000},  // release ID5 with flag
        '{1'b1, 4'd4,  8'h08, 32'h0000_0000},  // R4 free
        '{1'b0, 4'd6,  8'h00, 32'hA000_0000},  // claim ID5 without flag
        '{1'b1, 4'd6,  8'h08, 32'h0000_0000},  // R6 stays free
        '{1'b0, 4'd7,  8'h0C, 32'hD000_0000},  // claim g1, ID6
        '{1'b1, 4'd7,  8'h14, 32'hD000_0000},  // R7 g1 owner 6
        '{1'b1, 4'd7,  8'h08, 32'h0000_0000},  // R7 g0 untouched
        '{1'b1, 4'd7,  8'h20, 32'h0000_0000},  // R7 g2 untouched
        '{1'b0, 4'd10, 8'h18, 32'h1000_0000},  // claim g2, ID0
        '{1'b1, 4'd10, 8'h20, 32'h1000_0000},  // R10 owner 0 held
        '{1'b0, 4'd7,  8'h1C, 32'h1000_0000},  // release g2 via its own address
        '{1'b1, 4'd7,  8'h20, 32'h0000_0000},  // R7 g2 free
        '{1'b1, 4'd9,  8'h24, 32'h0000_0000},  // R9 unmapped read
        '{1'b0, 4'd9,  8'h24, 32'h3000_0000},  // R9 unmapped write
        '{1'b1, 4'd9,  8'h14, 32'hD000_0000}   // R9 g1 unchanged
    };

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(posedge clk); #1;
        d = rd_data;
        rd_en = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual hang expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] got;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            if (TABLE[i].is_rd) begin
                do_read(TABLE[i].addr, got);
                check(int'(TABLE[i].req), got, TABLE[i].val);
            end else begin
                do_write(TABLE[i].addr, TABLE[i].val);
            end
        end

        // R8: read and matching release of group 1 in the same cycle
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 8'h10; wr_data = 32'hD000_0000;
        rd_en = 1'b1; rd_addr = 8'h14;
        @(posedge clk); #1;
        got = rd_data;
        wr_en = 1'b0; rd_en = 1'b0;
        check(8, got, 32'hD000_0000);   // R8 old value seen
        do_read(8'h14, got);
        check(8, got, 32'h0000_0000);   // R8 release took effect

        // R8: claim and read in the same cycle on group 0
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 8'h00; wr_data = 32'h7000_0000;
        rd_en = 1'b1; rd_addr = 8'h08;
        @(posedge clk); #1;
        got = rd_data;
        wr_en = 1'b0; rd_en = 1'b0;
        check(8, got, 32'h0000_0000);
        do_read(8'h08, got);
        check(2, got, 32'h7000_0000);   // R2 owner 3

        // R1: reset while group 0 held clears it
        do_write(8'h18, 32'h9000_0000);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(1, rd_data, 32'h0000_0000);
        @(negedge clk);
        rst_n = 1'b1;
        do_read(8'h08, got);
        check(1, got, 32'h0000_0000);
        do_read(8'h20, got);
        check(1, got, 32'h0000_0000);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule